// File: doc/BRIEF.md
# In-Order Retirement Buffer

This block sits between issue and the architectural register file of an out-of-order core. Every issued instruction claims the next slot of a circular buffer, in program order, and receives that slot's index as its tag. Functional units later report results against the tag, in any order. The oldest slot retires once its result is present and no unresolved prediction still covers it. Each retirement produces one register write.

A fault reported by a functional unit is stored in the slot with a cause code. It has no effect until that slot is the oldest one and is no longer speculative. At that point the block reports the cause and the program counter of the faulting instruction, makes no register write, and empties the whole buffer. A branch that turns out mispredicted truncates the buffer just after the branch's own slot. The slots discarded this way never retire and never report a fault. Lookup ports let newly issued instructions read results that are complete but not yet retired.

Top module: `retire_queue`

## Requirements
- R1: Allocation hands out tags in ascending order modulo DEPTH, starting at 0 after reset. When DEPTH entries are held, `alloc_ready` is low and an allocation request neither takes a tag nor ever retires.
- R2: At most one entry retires per cycle, always the oldest. `commit_valid` shows that entry's destination and result.
- R3: Writebacks may arrive in any order. An entry whose result has arrived still waits for every older entry to retire.
- R4: A faulting oldest entry raises `exc_valid` for one cycle with its cause and PC. It does not raise `commit_valid` in that cycle, and the buffer is empty from the next cycle on, so `alloc_tag` equals the faulting entry's tag.
- R5: An entry allocated with `alloc_spec`=1 neither retires nor reports a fault until a `resolve_ok` pulse has been seen. The flag clears at the clock edge of that pulse.
- R6: With `mp_valid` and `mp_tag` naming a live entry, every younger entry is discarded. The next tag handed out is `mp_tag`+1, and lookups of discarded tags report not ready.
- R7: A discarded entry never raises `exc_valid`. A new instruction allocated into its slot starts with no result and no fault.
- R8: Lookup port k reports ready, with the stored result, only when `lk_tag` names a live entry whose result has arrived. This holds even when that entry is still speculative.
- R9: While a fault is reported, or while `mp_valid` is high, `alloc_ready` is low and allocation requests are dropped.
- R10: When two entries both hold faults, only the older one is reported. The younger one is discarded with the buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| alloc_valid | input | 1 | Issue requests a slot |
| alloc_dest | input | DEST_W | Destination register of the issued instruction |
| alloc_pc | input | PC_W | Program counter of the issued instruction |
| alloc_spec | input | 1 | Instruction issued under an unresolved prediction |
| alloc_ready | output | 1 | A request this cycle is accepted |
| alloc_tag | output | log2(DEPTH) | Tag given to a request this cycle |
| wb_valid | input | 1 | Functional unit result present |
| wb_tag | input | log2(DEPTH) | Tag of the completing entry |
| wb_data | input | DATA_W | Result value |
| wb_exc | input | 1 | Completing instruction faulted |
| wb_cause | input | CAUSE_W | Fault cause code |
| resolve_ok | input | 1 | Outstanding prediction confirmed; clears all speculative flags |
| mp_valid | input | 1 | Branch mispredicted |
| mp_tag | input | log2(DEPTH) | Tag of the mispredicted branch |
| lk_tag | input | LOOKUPS*log2(DEPTH) | Tags to look up, port k in slice k |
| lk_ready | output | LOOKUPS | Port k result available |
| lk_data | output | LOOKUPS*DATA_W | Port k result value |
| commit_valid | output | 1 | Register write this cycle |
| commit_dest | output | DEST_W | Register written |
| commit_data | output | DATA_W | Value written |
| exc_valid | output | 1 | Fault taken this cycle |
| exc_cause | output | CAUSE_W | Cause of the taken fault |
| exc_pc | output | PC_W | PC of the faulting instruction |

## Verification
The hardest situation to reach is a slot that still holds a stale fault while a retirement or a reallocation passes over it. To set it up, the bench writes faults into a younger entry and a still younger one, and then lets the older entry trap. In a separate scenario it sets a fault behind a branch, flushes it with a mispredict, and reallocates that same slot. Only then does it watch whether the leftover fault flag surfaces. The full-buffer case is reached by filling all slots with no writebacks before any completion is given.

// File: rtl/retire_pkg.sv
package retire_pkg;
   typedef enum logic [1:0] {
      HEAD_WAIT   = 2'd0,
      HEAD_RETIRE = 2'd1,
      HEAD_TRAP   = 2'd2
   } head_act_e;
endpackage

// File: rtl/retire_ptrs.sv
module retire_ptrs #(
   parameter int DEPTH = 8,
   parameter int IDX_W = $clog2(DEPTH),
   parameter int CNT_W = IDX_W + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic             pop,
   input  logic             trim,
   input  logic [IDX_W-1:0] trim_tag,
   input  logic             clear,
   output logic [IDX_W-1:0] head,
   output logic [IDX_W-1:0] tail,
   output logic [CNT_W-1:0] count,
   output logic             full
);
   logic [IDX_W-1:0] trim_off;
   logic [CNT_W-1:0] kept;

   assign trim_off = trim_tag - head;
   assign kept     = {1'b0, trim_off} + CNT_W'(1);
   assign full     = (count == CNT_W'(DEPTH));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         head  <= '0;
         tail  <= '0;
         count <= '0;
      end else if (clear) begin
         tail  <= head;
         count <= '0;
      end else begin
         if (pop) head <= head + 1'b1;
         if (trim) begin
            tail  <= trim_tag + 1'b1;
            count <= kept - CNT_W'(pop);
         end else begin
            if (push) tail <= tail + 1'b1;
            count <= count + CNT_W'(push) - CNT_W'(pop);
         end
      end
   end

   assert_no_overflow_R1: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CNT_W'(DEPTH));

   assert_pop_nonempty_R2: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> (count != '0));

   assert_trim_shrinks_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (trim && !clear) |=> (count <= $past(count)));
endmodule

// File: rtl/retire_entries.sv
module retire_entries #(
   parameter int DEPTH   = 8,
   parameter int DATA_W  = 32,
   parameter int DEST_W  = 5,
   parameter int CAUSE_W = 4,
   parameter int PC_W    = 32,
   parameter int LOOKUPS = 2,
   parameter int IDX_W   = $clog2(DEPTH),
   parameter int CNT_W   = IDX_W + 1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [IDX_W-1:0]          head,
   input  logic [CNT_W-1:0]          count,
   input  logic                      alloc_en,
   input  logic [IDX_W-1:0]          alloc_idx,
   input  logic [DEST_W-1:0]         alloc_dest,
   input  logic [PC_W-1:0]           alloc_pc,
   input  logic                      alloc_spec,
   input  logic                      wb_valid,
   input  logic [IDX_W-1:0]          wb_tag,
   input  logic [DATA_W-1:0]         wb_data,
   input  logic                      wb_exc,
   input  logic [CAUSE_W-1:0]        wb_cause,
   input  logic                      resolve_ok,
   input  logic [LOOKUPS*IDX_W-1:0]  lk_tag,
   output logic [LOOKUPS-1:0]        lk_ready,
   output logic [LOOKUPS*DATA_W-1:0] lk_data,
   output logic                      head_done,
   output logic                      head_spec,
   output logic                      head_exc,
   output logic [CAUSE_W-1:0]        head_cause,
   output logic [PC_W-1:0]           head_pc,
   output logic [DEST_W-1:0]         head_dest,
   output logic [DATA_W-1:0]         head_data
);
   logic [DEPTH-1:0]   done_v, spec_v, exc_v, live_v;
   logic [DATA_W-1:0]  data_a  [DEPTH];
   logic [DEST_W-1:0]  dest_a  [DEPTH];
   logic [PC_W-1:0]    pc_a    [DEPTH];
   logic [CAUSE_W-1:0] cause_a [DEPTH];

   for (genvar s = 0; s < DEPTH; s++) begin : g_slot
      logic [IDX_W-1:0]   off;
      logic               take, fill;
      logic               done_r, spec_r, exc_r;
      logic [DATA_W-1:0]  data_r;
      logic [DEST_W-1:0]  dest_r;
      logic [PC_W-1:0]    pc_r;
      logic [CAUSE_W-1:0] cause_r;

      assign off       = IDX_W'(s) - head;
      assign live_v[s] = ({1'b0, off} < count);
      assign take      = alloc_en && (alloc_idx == IDX_W'(s));
      assign fill      = wb_valid && (wb_tag == IDX_W'(s)) && live_v[s];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            done_r  <= 1'b0;
            spec_r  <= 1'b0;
            exc_r   <= 1'b0;
            data_r  <= '0;
            dest_r  <= '0;
            pc_r    <= '0;
            cause_r <= '0;
         end else if (take) begin
            done_r  <= 1'b0;
            exc_r   <= 1'b0;
            spec_r  <= alloc_spec;
            dest_r  <= alloc_dest;
            pc_r    <= alloc_pc;
         end else begin
            if (fill) begin
               done_r  <= 1'b1;
               data_r  <= wb_data;
               exc_r   <= wb_exc;
               cause_r <= wb_cause;
            end
            if (resolve_ok) spec_r <= 1'b0;
         end
      end

      assign done_v[s]  = done_r;
      assign spec_v[s]  = spec_r;
      assign exc_v[s]   = exc_r;
      assign data_a[s]  = data_r;
      assign dest_a[s]  = dest_r;
      assign pc_a[s]    = pc_r;
      assign cause_a[s] = cause_r;
   end

   for (genvar k = 0; k < LOOKUPS; k++) begin : g_look
      logic [IDX_W-1:0] t;
      assign t           = lk_tag[k*IDX_W +: IDX_W];
      assign lk_ready[k] = live_v[t] && done_v[t];
      assign lk_data[k*DATA_W +: DATA_W] = data_a[t];
   end

   assign head_done  = done_v[head];
   assign head_spec  = spec_v[head];
   assign head_exc   = exc_v[head];
   assign head_cause = cause_a[head];
   assign head_pc    = pc_a[head];
   assign head_dest  = dest_a[head];
   assign head_data  = data_a[head];

   assert_alloc_free_R1: assert property (@(posedge clk) disable iff (!rst_n)
      alloc_en |-> !live_v[alloc_idx]);

   assert_alloc_fresh_R7: assert property (@(posedge clk) disable iff (!rst_n)
      alloc_en |=> !done_v[$past(alloc_idx)] && !exc_v[$past(alloc_idx)]);
endmodule

// File: rtl/retire_queue.sv
module retire_queue
   import retire_pkg::*;
#(
   parameter int DEPTH   = 8,
   parameter int DATA_W  = 32,
   parameter int DEST_W  = 5,
   parameter int CAUSE_W = 4,
   parameter int PC_W    = 32,
   parameter int LOOKUPS = 2
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              alloc_valid,
   input  logic [DEST_W-1:0]                 alloc_dest,
   input  logic [PC_W-1:0]                   alloc_pc,
   input  logic                              alloc_spec,
   output logic                              alloc_ready,
   output logic [$clog2(DEPTH)-1:0]          alloc_tag,
   input  logic                              wb_valid,
   input  logic [$clog2(DEPTH)-1:0]          wb_tag,
   input  logic [DATA_W-1:0]                 wb_data,
   input  logic                              wb_exc,
   input  logic [CAUSE_W-1:0]                wb_cause,
   input  logic                              resolve_ok,
   input  logic                              mp_valid,
   input  logic [$clog2(DEPTH)-1:0]          mp_tag,
   input  logic [LOOKUPS*$clog2(DEPTH)-1:0]  lk_tag,
   output logic [LOOKUPS-1:0]                lk_ready,
   output logic [LOOKUPS*DATA_W-1:0]         lk_data,
   output logic                              commit_valid,
   output logic [DEST_W-1:0]                 commit_dest,
   output logic [DATA_W-1:0]                 commit_data,
   output logic                              exc_valid,
   output logic [CAUSE_W-1:0]                exc_cause,
   output logic [PC_W-1:0]                   exc_pc
);
   localparam int IDX_W = $clog2(DEPTH);
   localparam int CNT_W = IDX_W + 1;

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("retire_queue: DEPTH must be a power of two of at least 2");
   end
   if (LOOKUPS < 1) begin : g_bad_look
      $error("retire_queue: LOOKUPS must be at least 1");
   end
   if (DATA_W < 1 || DEST_W < 1 || CAUSE_W < 1 || PC_W < 1) begin : g_bad_width
      $error("retire_queue: widths must be positive");
   end

   logic [IDX_W-1:0]   head, tail, mp_off;
   logic [CNT_W-1:0]   count;
   logic               full, push, trim;
   logic               head_done, head_spec, head_exc;
   logic [CAUSE_W-1:0] head_cause;
   logic [PC_W-1:0]    head_pc;
   logic [DEST_W-1:0]  head_dest;
   logic [DATA_W-1:0]  head_data;
   head_act_e          act;

   always_comb begin
      act = HEAD_WAIT;
      if (count != '0 && head_done && !head_spec)
         act = head_exc ? HEAD_TRAP : HEAD_RETIRE;
   end

   assign mp_off      = mp_tag - head;
   assign trim        = mp_valid && ({1'b0, mp_off} < count) && (act != HEAD_TRAP);
   assign alloc_ready = !full && !mp_valid && (act != HEAD_TRAP);
   assign push        = alloc_valid && alloc_ready;
   assign alloc_tag   = tail;

   assign commit_valid = (act == HEAD_RETIRE);
   assign commit_dest  = head_dest;
   assign commit_data  = head_data;
   assign exc_valid    = (act == HEAD_TRAP);
   assign exc_cause    = head_cause;
   assign exc_pc       = head_pc;

   retire_ptrs #(.DEPTH(DEPTH), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_ptrs (
      .clk      (clk),
      .rst_n    (rst_n),
      .push     (push),
      .pop      (commit_valid),
      .trim     (trim),
      .trim_tag (mp_tag),
      .clear    (exc_valid),
      .head     (head),
      .tail     (tail),
      .count    (count),
      .full     (full)
   );

   retire_entries #(
      .DEPTH(DEPTH), .DATA_W(DATA_W), .DEST_W(DEST_W), .CAUSE_W(CAUSE_W),
      .PC_W(PC_W), .LOOKUPS(LOOKUPS), .IDX_W(IDX_W), .CNT_W(CNT_W)
   ) u_entries (
      .clk        (clk),
      .rst_n      (rst_n),
      .head       (head),
      .count      (count),
      .alloc_en   (push),
      .alloc_idx  (tail),
      .alloc_dest (alloc_dest),
      .alloc_pc   (alloc_pc),
      .alloc_spec (alloc_spec),
      .wb_valid   (wb_valid),
      .wb_tag     (wb_tag),
      .wb_data    (wb_data),
      .wb_exc     (wb_exc),
      .wb_cause   (wb_cause),
      .resolve_ok (resolve_ok),
      .lk_tag     (lk_tag),
      .lk_ready   (lk_ready),
      .lk_data    (lk_data),
      .head_done  (head_done),
      .head_spec  (head_spec),
      .head_exc   (head_exc),
      .head_cause (head_cause),
      .head_pc    (head_pc),
      .head_dest  (head_dest),
      .head_data  (head_data)
   );

   assert_full_refuse_R1: assert property (@(posedge clk) disable iff (!rst_n)
      full |-> !alloc_ready);

   assert_single_outcome_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !(commit_valid && exc_valid));

   assert_retire_advances_R2: assert property (@(posedge clk) disable iff (!rst_n)
      commit_valid |=> (head == $past(head) + 1'b1));

   assert_trap_empties_R4: assert property (@(posedge clk) disable iff (!rst_n)
      exc_valid |=> (count == '0));

   assert_spec_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (commit_valid || exc_valid) |-> !head_spec);

   assert_flush_blocks_alloc_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (mp_valid || exc_valid) |-> !push);
endmodule

// File: tb/retire_queue_bench.sv
module retire_queue_bench;
   localparam int DEPTH = 8, DATA_W = 32, DEST_W = 5, CAUSE_W = 4, PC_W = 32, LOOKUPS = 2;
   localparam int IW = $clog2(DEPTH);

   logic clk = 1'b0, rst_n = 1'b0;
   logic alloc_valid, alloc_spec, alloc_ready;
   logic [DEST_W-1:0] alloc_dest;
   logic [PC_W-1:0] alloc_pc;
   logic [IW-1:0] alloc_tag, wb_tag, mp_tag;
   logic wb_valid, wb_exc, resolve_ok, mp_valid;
   logic [DATA_W-1:0] wb_data;
   logic [CAUSE_W-1:0] wb_cause;
   logic [LOOKUPS*IW-1:0] lk_tag;
   logic [LOOKUPS-1:0] lk_ready;
   logic [LOOKUPS*DATA_W-1:0] lk_data;
   logic commit_valid, exc_valid;
   logic [DEST_W-1:0] commit_dest;
   logic [DATA_W-1:0] commit_data;
   logic [CAUSE_W-1:0] exc_cause;
   logic [PC_W-1:0] exc_pc;

   int total = 0, failed = 0;

   always #4 clk = ~clk;

   retire_queue u_retire_queue (
      .clk(clk), .rst_n(rst_n),
      .alloc_valid(alloc_valid), .alloc_dest(alloc_dest), .alloc_pc(alloc_pc),
      .alloc_spec(alloc_spec), .alloc_ready(alloc_ready), .alloc_tag(alloc_tag),
      .wb_valid(wb_valid), .wb_tag(wb_tag), .wb_data(wb_data), .wb_exc(wb_exc),
      .wb_cause(wb_cause), .resolve_ok(resolve_ok), .mp_valid(mp_valid), .mp_tag(mp_tag),
      .lk_tag(lk_tag), .lk_ready(lk_ready), .lk_data(lk_data),
      .commit_valid(commit_valid), .commit_dest(commit_dest), .commit_data(commit_data),
      .exc_valid(exc_valid), .exc_cause(exc_cause), .exc_pc(exc_pc)
   );

   task automatic chk(input string req, input string what, input longint act, input longint exp);
      total++;
      if (act != exp) begin
         failed++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic idle();
      alloc_valid = 0; alloc_dest = '0; alloc_pc = '0; alloc_spec = 0;
      wb_valid = 0; wb_tag = '0; wb_data = '0; wb_exc = 0; wb_cause = '0;
      resolve_ok = 0; mp_valid = 0; mp_tag = '0;
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
      idle();
      #1;
   endtask

   task automatic alloc(input int dest, input int pc, input bit spec);
      alloc_valid = 1; alloc_dest = DEST_W'(dest); alloc_pc = PC_W'(pc); alloc_spec = spec;
   endtask

   task automatic wb(input int tag, input int data, input bit exc, input int cause);
      wb_valid = 1; wb_tag = IW'(tag); wb_data = DATA_W'(data); wb_exc = exc;
      wb_cause = CAUSE_W'(cause);
   endtask

   task automatic look(input int port, input int tag);
      lk_tag[port*IW +: IW] = IW'(tag);
      #1;
   endtask

   task automatic test_reset();
      chk("R1", "alloc_ready after reset", alloc_ready, 1);
      chk("R1", "alloc_tag after reset", alloc_tag, 0);
      chk("R2", "commit_valid after reset", commit_valid, 0);
      chk("R4", "exc_valid after reset", exc_valid, 0);
      look(0, 0);
      chk("R8", "lookup empty buffer", lk_ready[0], 0);
   endtask

   task automatic test_order();
      for (int k = 0; k < 3; k++) begin
         alloc(1 + k, 16 + 4 * k, 0); #1;
         chk("R1", "tag in order", alloc_tag, k);
         tick();
      end
      wb(2, 'hC3, 0, 0); tick();
      chk("R3", "young done, head pending", commit_valid, 0);
      look(0, 2); look(1, 1);
      chk("R8", "lookup done entry ready", lk_ready[0], 1);
      chk("R8", "lookup done entry data", lk_data[31:0], 'hC3);
      chk("R8", "lookup pending entry", lk_ready[1], 0);
      wb(1, 'hB2, 0, 0); tick();
      chk("R3", "still waiting on oldest", commit_valid, 0);
      wb(0, 'hA1, 0, 0); tick();
      chk("R2", "first commit valid", commit_valid, 1);
      chk("R2", "first commit dest", commit_dest, 1);
      chk("R2", "first commit data", commit_data, 'hA1);
      tick();
      chk("R2", "second commit dest", commit_dest, 2);
      chk("R2", "second commit data", commit_data, 'hB2);
      tick();
      chk("R2", "third commit dest", commit_dest, 3);
      chk("R2", "third commit data", commit_data, 'hC3);
      tick();
      chk("R2", "drained", commit_valid, 0);
      chk("R1", "next tag", alloc_tag, 3);
      look(0, 0);
      chk("R8", "retired entry not ready", lk_ready[0], 0);
   endtask

   task automatic test_full();
      int commits = 0;
      for (int k = 0; k < DEPTH; k++) begin
         alloc(8 + k, 'h40 + k, 0); #1;
         chk("R1", "fill tag", alloc_tag, (3 + k) % DEPTH);
         tick();
      end
      chk("R1", "full refuses", alloc_ready, 0);
      alloc(31, 0, 0); #1;
      chk("R1", "full refuses under request", alloc_ready, 0);
      tick();
      chk("R1", "tag unchanged when full", alloc_tag, 3);
      for (int k = 0; k < DEPTH + 4; k++) begin
         if (k < DEPTH) wb((3 + k) % DEPTH, 'h40 + k, 0, 0);
         #1;
         if (commit_valid) begin
            chk("R2", "full drain order", commit_dest, 8 + commits);
            commits++;
         end
         tick();
      end
      chk("R1", "refused request never retires", commits, DEPTH);
      chk("R1", "tag after wrap", alloc_tag, 3);
   endtask

   task automatic test_spec();
      alloc(20, 'h90, 1); tick();
      wb(3, 'h99, 0, 0); tick();
      chk("R5", "speculative done held", commit_valid, 0);
      tick();
      chk("R5", "speculative still held", commit_valid, 0);
      look(0, 3);
      chk("R8", "speculative result visible", lk_ready[0], 1);
      resolve_ok = 1; #1;
      chk("R5", "held during resolve cycle", commit_valid, 0);
      tick();
      chk("R5", "retires after resolve", commit_valid, 1);
      chk("R5", "retire dest", commit_dest, 20);
      tick();
   endtask

   task automatic test_trap();
      alloc(21, 'h100, 0); tick();
      alloc(22, 'h104, 0); tick();
      alloc(23, 'h108, 0); tick();
      wb(6, 0, 1, 5); tick();
      chk("R10", "young fault held", exc_valid, 0);
      wb(5, 0, 1, 3); tick();
      chk("R4", "fault behind pending head held", exc_valid, 0);
      wb(4, 'h77, 0, 0); tick();
      chk("R2", "clean head retires", commit_valid, 1);
      chk("R2", "clean head dest", commit_dest, 21);
      chk("R4", "no fault yet", exc_valid, 0);
      tick();
      chk("R4", "fault taken", exc_valid, 1);
      chk("R10", "oldest cause", exc_cause, 3);
      chk("R10", "oldest pc", exc_pc, 'h104);
      chk("R4", "no write with fault", commit_valid, 0);
      chk("R9", "no alloc during fault", alloc_ready, 0);
      tick();
      chk("R10", "younger fault dropped", exc_valid, 0);
      chk("R4", "empty after fault", commit_valid, 0);
      chk("R4", "tag restarts at faulting slot", alloc_tag, 5);
      look(0, 6);
      chk("R7", "flushed slot not ready", lk_ready[0], 0);
      tick();
      chk("R7", "still no fault", exc_valid, 0);
   endtask

   task automatic test_mispredict();
      alloc(0, 'h200, 0); tick();
      alloc(24, 'h204, 1); tick();
      alloc(25, 'h208, 1); tick();
      wb(6, 0, 1, 9); tick();
      wb(7, 'h88, 0, 0); tick();
      mp_valid = 1; mp_tag = 5; alloc(30, 'h300, 0); #1;
      chk("R9", "alloc refused in mispredict", alloc_ready, 0);
      tick();
      chk("R6", "tag after branch", alloc_tag, 6);
      look(1, 7);
      chk("R6", "discarded entry not visible", lk_ready[1], 0);
      wb(5, 'h55, 0, 0); tick();
      chk("R6", "branch retires", commit_valid, 1);
      chk("R6", "branch dest", commit_dest, 0);
      chk("R6", "branch data", commit_data, 'h55);
      for (int k = 0; k < 3; k++) begin
         tick();
         chk("R7", "discarded fault silent", exc_valid, 0);
         chk("R6", "discarded entry silent", commit_valid, 0);
      end
      alloc(26, 'h20C, 0); #1;
      chk("R6", "reused slot tag", alloc_tag, 6);
      tick();
      look(0, 6);
      chk("R7", "reused slot starts empty", lk_ready[0], 0);
      wb(6, 'h66, 0, 0); tick();
      chk("R7", "reused slot retires clean", commit_valid, 1);
      chk("R7", "reused slot no stale fault", exc_valid, 0);
      chk("R7", "reused slot data", commit_data, 'h66);
      tick();
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", total - failed, total);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      total++; failed++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
   end

   initial begin
      idle();
      lk_tag = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      test_reset();
      test_order();
      test_full();
      test_spec();
      test_trap();
      test_mispredict();
      summary();
      $finish;
   end
endmodule